// File: doc/BRIEF.md
# Power-on reset sequencer

This block is a synchronous controller placed in an FPGA that generates the reset lines of an attached processor. It drives two active-low outputs: a power-on reset and a warm reset. It holds both of them asserted until every supply-good indication is true and the local clock generator reports lock. It then holds the warm reset for a minimum time and releases it. After that it holds the power-on reset for a second minimum time and releases it. Finally it waits for the processor's reset-status pin to go high.

Each minimum hold has two limits, and both must be met. The first is a count of controller clock cycles, which covers the millisecond-scale delays. The second is a count of reference-clock cycles, presented to the block as one-cycle tick strobes. A configuration strap selects which of the two reference ticks is counted. If the processor never reports that it is out of reset, the sequencer sets a sticky error flag, asserts both lines again and retries. Any loss of a supply or of clock lock restarts the whole sequence at once.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the block presents the following values:
  - `por_n_o`, `warm_n_o`, `ready_o`, `done_o` and `err_o` are 0.
  - `state_o` is 0.
- R2: `state_o` stays 0 (wait for power) and both reset outputs stay low for as long as any bit of `supply_good` is 0 or `gen_locked` is 0.
- R3: The block stays in state 1 (warm and power-on both held) for at least `WARM_CYC`+1 controller cycles. It also stays there until `REF_MIN` selected reference ticks have been counted. When the ticks arrive every cycle, state 1 lasts exactly `WARM_CYC`+1 cycles.
- R4: The strap selects which reference tick is counted. With `alt_ref_strap`=1 the block counts `ref_pri_tick`; with `alt_ref_strap`=0 it counts `ref_sec_tick`. Ticks on the input that is not selected have no effect.
- R5: The warm reset is always released first. The block then stays in state 2 (power-on held, warm released) for at least `POR_CYC`+1 cycles and for at least `REF_MIN` selected ticks; with a tick every cycle, state 2 lasts exactly `POR_CYC`+1 cycles. `por_n_o`=1 never occurs while `warm_n_o`=0.
- R6: `cpu_status` passes through a two-flop synchroniser and is acted on only in state 3 (wait for status). A high level during the hold states never raises `ready_o`. A rise during state 3 sets `ready_o` on the third rising edge after the change.
- R7: On entry to state 4 (ready), `done_o` is high for exactly one cycle. `ready_o` stays high for as long as the state is 4.
- R8: If `gen_locked` or any `supply_good` bit drops, the next rising edge sets the following:
  - `state_o` to 0.
  - Both reset outputs low.
  - `ready_o` low.
- R9: If the synchronised status has not been seen high while state 3 has lasted `STAT_TIMEOUT`+1 cycles, the block does the following:
  - It drives `por_n_o` low again.
  - It enters state 5 (fault) for one cycle and then state 0.
  - It sets `err_o`, which stays 1 until `rst_n` is asserted.
- R10: `state_o` uses this encoding: 0 wait for power, 1 hold both, 2 hold power-on, 3 wait for status, 4 ready, 5 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset of the controller itself |
| supply_good | input | N_SUPPLY | Supply-good indications, all must be 1 |
| gen_locked | input | 1 | Local clock generator lock flag |
| alt_ref_strap | input | 1 | 1: count primary reference ticks, 0: count secondary |
| ref_pri_tick | input | 1 | One-cycle strobe per primary reference clock cycle |
| ref_sec_tick | input | 1 | One-cycle strobe per secondary reference clock cycle |
| cpu_status | input | 1 | Processor reset-status pin, asynchronous |
| por_n_o | output | 1 | Power-on reset to the processor, active low |
| warm_n_o | output | 1 | Warm reset to the processor, active low |
| ready_o | output | 1 | Processor reported out of reset |
| done_o | output | 1 | One-cycle pulse on entering ready |
| err_o | output | 1 | Sticky status-timeout flag |
| state_o | output | 3 | Sequencer state code |

## Verification
The bench builds the block with `N_SUPPLY`=3, `WARM_CYC`=40, `POR_CYC`=60, `REF_MIN`=8 and `STAT_TIMEOUT`=50. With these values every hold and the timeout take a few dozen cycles, so each one can be measured exactly. With a tick spacing of up to 20 cycles, the reference-tick limit becomes the longer of the two limits, so it can be checked that it sets the hold length. Random rounds mix the strap setting, the tick spacing, lock glitches placed in the middle of a hold, and the delay before the status pin rises.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PWR  = 3'd0,
    ST_HOLD_ALL  = 3'd1,
    ST_HOLD_POR  = 3'd2,
    ST_WAIT_STAT = 3'd3,
    ST_READY     = 3'd4,
    ST_FAULT     = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic por_n;
    logic warm_n;
  } rst_lines_t;

  // Reset line levels as a pure function of the sequencer state
  function automatic rst_lines_t lines_for(seq_state_e s);
    rst_lines_t l;
    l.por_n  = (s == ST_WAIT_STAT) || (s == ST_READY);
    l.warm_n = (s == ST_HOLD_POR) || (s == ST_WAIT_STAT) || (s == ST_READY);
    return l;
  endfunction

  // Counter width able to hold the value lim
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q_sync <= 1'b0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/rstseq_hold_timer.sv
module rstseq_hold_timer
  import rstseq_pkg::*;
#(
  parameter int unsigned CYC_LIM  = 1,
  parameter int unsigned TICK_LIM = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = cnt_width(CYC_LIM);
  localparam int unsigned TW = cnt_width(TICK_LIM);

  logic [CW-1:0] cyc_q;
  logic [TW-1:0] tck_q;
  logic          cyc_met;
  logic          tck_met;

  assign cyc_met = (cyc_q == CW'(CYC_LIM));
  assign tck_met = (tck_q == TW'(TICK_LIM));

  // Both counters saturate; leaving run clears them for the next hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      tck_q <= '0;
    end else if (!run) begin
      cyc_q <= '0;
      tck_q <= '0;
    end else begin
      if (!cyc_met)         cyc_q <= cyc_q + 1'b1;
      if (tick && !tck_met) tck_q <= tck_q + 1'b1;
    end
  end

  assign done = run && cyc_met && tck_met;

  // R3/R5: a hold can only finish if the timer was already running
  p_done_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));
  // R3/R5: once stopped, the timer starts again from zero
  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned N_SUPPLY     = 3,
  parameter int unsigned WARM_CYC     = 2_000_000,
  parameter int unsigned POR_CYC      = 4_000_000,
  parameter int unsigned REF_MIN      = 256,
  parameter int unsigned STAT_TIMEOUT = 1_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SUPPLY-1:0] supply_good,
  input  logic                gen_locked,
  input  logic                alt_ref_strap,
  input  logic                ref_pri_tick,
  input  logic                ref_sec_tick,
  input  logic                cpu_status,
  output logic                por_n_o,
  output logic                warm_n_o,
  output logic                ready_o,
  output logic                done_o,
  output logic                err_o,
  output logic [2:0]          state_o
);
  seq_state_e state_q, state_nx;
  rst_lines_t lines;

  // Named internal events
  logic pwr_ok;
  logic ref_tick;
  logic stat_s;
  logic warm_hold_done;
  logic por_hold_done;
  logic wait_expired;
  logic take_ready;
  logic take_fault;
  logic done_q;
  logic err_q;

  assign pwr_ok   = (&supply_good) && gen_locked;
  assign ref_tick = alt_ref_strap ? ref_pri_tick : ref_sec_tick;

  rstseq_sync2 u_stat_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cpu_status),
    .q_sync  (stat_s)
  );

  rstseq_hold_timer #(.CYC_LIM(WARM_CYC), .TICK_LIM(REF_MIN)) u_warm_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_HOLD_ALL),
    .tick  (ref_tick),
    .done  (warm_hold_done)
  );

  rstseq_hold_timer #(.CYC_LIM(POR_CYC), .TICK_LIM(REF_MIN)) u_por_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_HOLD_POR),
    .tick  (ref_tick),
    .done  (por_hold_done)
  );

  rstseq_hold_timer #(.CYC_LIM(STAT_TIMEOUT), .TICK_LIM(1)) u_stat_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_WAIT_STAT),
    .tick  (1'b1),
    .done  (wait_expired)
  );

  assign take_ready = pwr_ok && (state_q == ST_WAIT_STAT) && stat_s;
  assign take_fault = pwr_ok && (state_q == ST_WAIT_STAT) && !stat_s && wait_expired;

  always_comb begin
    state_nx = state_q;
    if (!pwr_ok) begin
      state_nx = ST_WAIT_PWR;
    end else begin
      unique case (state_q)
        ST_WAIT_PWR:  state_nx = ST_HOLD_ALL;
        ST_HOLD_ALL:  if (warm_hold_done) state_nx = ST_HOLD_POR;
        ST_HOLD_POR:  if (por_hold_done)  state_nx = ST_WAIT_STAT;
        ST_WAIT_STAT: begin
          if (take_ready)      state_nx = ST_READY;
          else if (take_fault) state_nx = ST_FAULT;
        end
        ST_READY:     state_nx = ST_READY;
        ST_FAULT:     state_nx = ST_WAIT_PWR;
        default:      state_nx = ST_WAIT_PWR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_PWR;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      done_q  <= take_ready;
      err_q   <= err_q | take_fault;
    end
  end

  assign lines    = lines_for(state_q);
  assign por_n_o  = lines.por_n;
  assign warm_n_o = lines.warm_n;
  assign ready_o  = (state_q == ST_READY);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign state_o  = state_q;

  // R5: release order of the two lines
  p_por_after_warm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    por_n_o |-> warm_n_o);
  // R8: losing power or lock reasserts everything on the next edge
  p_drop_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (state_o == 3'd0 && !por_n_o && !warm_n_o && !ready_o));
  // R2: nothing is released while power or lock is missing
  p_hold_without_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> (!por_n_o && !warm_n_o));
  // R6: ready only with power-on reset released
  p_ready_needs_por_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> por_n_o);
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: the error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R9: a timeout goes to fault, then restarts from the beginning
  p_fault_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> (state_o == 3'd5 && err_o && !por_n_o));
  p_fault_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |=> (state_o == 3'd0));
  // R10: only the six defined codes appear
  p_state_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);
endmodule

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int NS = 3;
  localparam int WC = 40;
  localparam int PC = 60;
  localparam int RM = 8;
  localparam int TO = 50;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NS-1:0] supply_good = '0;
  logic          gen_locked = 1'b0;
  logic          alt_ref_strap = 1'b0;
  logic          ref_pri_tick = 1'b0;
  logic          ref_sec_tick = 1'b0;
  logic          cpu_status = 1'b0;
  logic          por_n_o, warm_n_o, ready_o, done_o, err_o;
  logic [2:0]    state_o;

  int checks = 0;
  int errors = 0;
  int per_p = 0;
  int per_s = 0;
  int tcnt = 0;
  bit finished = 0;

  rst_sequencer #(
    .N_SUPPLY(NS), .WARM_CYC(WC), .POR_CYC(PC), .REF_MIN(RM), .STAT_TIMEOUT(TO)
  ) u_rst_sequencer (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .gen_locked(gen_locked),
    .alt_ref_strap(alt_ref_strap), .ref_pri_tick(ref_pri_tick), .ref_sec_tick(ref_sec_tick),
    .cpu_status(cpu_status), .por_n_o(por_n_o), .warm_n_o(warm_n_o), .ready_o(ready_o),
    .done_o(done_o), .err_o(err_o), .state_o(state_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bounds on a hold length for a given cycle minimum and tick spacing
  function automatic int hold_lo(input int n, input int per);
    return max2(n + 1, (RM - 1) * per + 1);
  endfunction
  function automatic int hold_hi(input int n, input int per);
    return max2(n, per * RM) + per + 3;
  endfunction

  // One cycle: sample after the falling edge, check invariants, then drive ticks
  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      check(!(por_n_o && !warm_n_o), "R5 order", por_n_o, 0);
      check(!(ready_o && !por_n_o), "R6 ready without por", ready_o, 0);
    end
    tcnt++;
    ref_pri_tick = (per_p != 0) && (tcnt % per_p == 0);
    ref_sec_tick = (per_s != 0) && (tcnt % per_s == 0);
  endtask

  task automatic wait_state(input int st, input int lim);
    int n = 0;
    while (state_o != 3'(st) && n < lim) begin
      cyc();
      n++;
    end
  endtask

  task automatic measure(input int st, output int len);
    wait_state(st, 2000);
    len = 0;
    while (state_o == 3'(st) && len < 5000) begin
      len++;
      cyc();
    end
  endtask

  task automatic restart();
    gen_locked = 1'b0;
    cyc();
    gen_locked = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    int dly;
    void'($urandom(32'h5eed_0042));

    // R1: reset state
    repeat (3) cyc();
    check(!por_n_o && !warm_n_o, "R1 lines in reset", {por_n_o, warm_n_o}, 0);
    check(!ready_o && !done_o && !err_o, "R1 flags in reset", {ready_o, done_o, err_o}, 0);
    check(state_o == 3'd0, "R1 state in reset", state_o, 0);
    rst_n = 1'b1;
    cyc();
    check(state_o == 3'd0 && !por_n_o, "R1 first cycle after reset", state_o, 0);

    // R2: partial supplies, then no lock
    alt_ref_strap = 1'b1; per_p = 1;
    supply_good = 3'b011; gen_locked = 1'b1;
    repeat (30) cyc();
    check(state_o == 3'd0 && !warm_n_o && !por_n_o, "R2 supply missing", state_o, 0);
    supply_good = 3'b111; gen_locked = 1'b0;
    repeat (20) cyc();
    check(state_o == 3'd0 && !warm_n_o && !por_n_o, "R2 lock missing", state_o, 0);

    // R3 / R5 / R10: exact holds with a tick every cycle
    gen_locked = 1'b1;
    measure(1, len);
    check(len == WC + 1, "R3 warm hold length", len, WC + 1);
    check(state_o == 3'd2 && warm_n_o && !por_n_o, "R5 warm released first", state_o, 2);
    measure(2, len);
    check(len == PC + 1, "R5 por hold length", len, PC + 1);
    check(state_o == 3'd3 && por_n_o, "R10 wait-status code", state_o, 3);

    // R6 / R7: status latency and done pulse
    repeat (4) cyc();
    cpu_status = 1'b1;
    cyc();
    check(!ready_o, "R6 sync stage 1", ready_o, 0);
    cyc();
    check(!ready_o, "R6 sync stage 2", ready_o, 0);
    cyc();
    check(ready_o && done_o && state_o == 3'd4, "R6 ready on third edge", {ready_o, done_o}, 3);
    cyc();
    check(ready_o && !done_o, "R7 done single cycle", {ready_o, done_o}, 2);
    repeat (10) cyc();
    check(ready_o && !done_o, "R7 ready level holds", {ready_o, done_o}, 2);

    // R8: lock loss
    cpu_status = 1'b0;
    gen_locked = 1'b0;
    cyc();
    check(state_o == 3'd0 && !por_n_o && !warm_n_o && !ready_o, "R8 lock drop", state_o, 0);
    gen_locked = 1'b1;

    // R4: secondary selected but silent, primary running fast
    alt_ref_strap = 1'b0; per_p = 1; per_s = 0;
    repeat (300) cyc();
    check(state_o == 3'd1 && !warm_n_o, "R4 unselected ticks ignored", state_o, 1);
    per_s = 20;
    restart();
    measure(1, len);
    check(len >= hold_lo(WC, 20) && len <= hold_hi(WC, 20), "R3 tick-limited hold", len, hold_lo(WC, 20));

    // R6: status high during power-on hold is not acted upon
    cpu_status = 1'b1;
    while (state_o == 3'd2) begin
      check(!ready_o, "R6 status ignored while held", ready_o, 0);
      cyc();
    end
    repeat (2) cyc();
    check(ready_o, "R6 ready after release", ready_o, 1);

    // R9: timeout, fault, retry, sticky error
    cpu_status = 1'b0;
    alt_ref_strap = 1'b1; per_p = 1; per_s = 0;
    restart();
    measure(3, len);
    check(len == TO + 1, "R9 timeout length", len, TO + 1);
    check(state_o == 3'd5 && err_o && !por_n_o, "R9 fault state", state_o, 5);
    cyc();
    check(state_o == 3'd0, "R9 retry from start", state_o, 0);
    wait_state(3, 500);
    cpu_status = 1'b1;
    wait_state(4, 10);
    check(ready_o && err_o, "R9 error sticky after success", err_o, 1);

    // R1: controller reset clears the sticky flag
    rst_n = 1'b0;
    cyc();
    check(!err_o && state_o == 3'd0, "R1 reset clears error", err_o, 0);
    rst_n = 1'b1;
    cpu_status = 1'b0;

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      int per;
      alt_ref_strap = $urandom % 2;
      per = 1 + ($urandom % 4);
      if (alt_ref_strap) begin per_p = per; per_s = $urandom % 5; end
      else               begin per_s = per; per_p = $urandom % 5; end
      restart();
      if ($urandom % 2) begin
        wait_state(1, 100);
        repeat ($urandom % 30) cyc();
        gen_locked = 1'b0;
        cyc();
        check(state_o == 3'd0 && !warm_n_o, "R8 glitch in hold", state_o, 0);
        gen_locked = 1'b1;
      end
      measure(1, len);
      check(len >= hold_lo(WC, per) && len <= hold_hi(WC, per), "R3 random warm hold", len, hold_lo(WC, per));
      measure(2, len);
      check(len >= hold_lo(PC, per) && len <= hold_hi(PC, per), "R5 random por hold", len, hold_lo(PC, per));
      dly = $urandom % (TO - 5);
      repeat (dly) cyc();
      cpu_status = 1'b1;
      wait_state(4, 6);
      check(ready_o && !err_o, "R6 random ready", ready_o, 1);
      cpu_status = 1'b0;
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule